// File: doc/BRIEF.md
# Datapath Signature Self-Test Unit

This unit tests a channel's signal path by feeding it a chosen stimulus and compacting what comes out into two signatures, one for the in-phase (I) word and one for the quadrature (Q) word. The stimulus can be one of three sources. The first is vectors supplied from outside over a valid/ready stream. The second is an internal 16-bit pseudo-random sequence. The third is an internal sine/cosine pattern held in a small table that is computed at elaboration. The signal path under test is modelled as one registered stage that applies a fixed left shift (a gain).

Software follows a fixed sequence. It writes both signature registers to zero, writes the number of path outputs to observe, and writes the stimulus mode. It then raises `sync`, which takes the unit out of sleep. Each accepted path output is folded into the two signature registers. When the programmed count is reached, `done` rises and both signatures freeze. Software reads `sig_i` and `sig_q` and compares them with known-good values.

Back-pressure works as follows:
- External vectors move only on a cycle where `ext_valid` and `ext_ready` are both high. `ext_ready` is low unless a run is active, the external source is selected, `ext_en` is high and the stage has room.
- A path output counts only on a cycle where `out_valid` and `out_ready` are both high.
- While `out_ready` is low, the presented output word is held unchanged.

Top module: `path_sig_tester`

## Requirements
- R1: After reset the unit sleeps: `busy`, `done`, `out_valid` and `ext_ready` are low, and both signatures are zero.
- R2: Writes use `cfg_addr`, with one register per address value:

  | `cfg_addr` | Register |
  |---|---|
  | 0 | Observation count, taken from bits 19:0 |
  | 1 | Stimulus mode |
  | 2 | Loads `sig_i` from all 24 data bits |
  | 3 | Loads `sig_q` from all 24 data bits |

  In the mode register, bit 7 high selects the pseudo-random source. Bit 6 high with bit 7 clear selects the sine source. Both clear selects external vectors. While `busy` is high, every write is ignored.
- R3: A `sync` pulse while sleeping makes `busy` high from the next cycle. If the programmed count is zero, the unit goes straight to `done` and nothing is compacted.
- R4: The pseudo-random source is a 16-bit LFSR.
  - It is reloaded with 0xACE1 at every run start.
  - It steps as next = {s[14:0], s15^s13^s12^s10} once per taken sample.
  - The I sample is s and the Q sample is {s[7:0], s[15:8]}.
- R5: The sine source uses a phase p in the range 0 to L-1, where L is the table length and h = L/2.
  - p is reset at run start and advances once per taken sample.
  - The value is A·4·r·(h−r)/(h·h) with integer division, where r = p mod h and A = 2^(DATA_W−2). The value is negated when p ≥ h.
  - I uses p and Q uses (p + L/4) mod L.
- R6: `ext_ready` is high only while `busy` and `ext_en` are high and mode is external. Vectors transfer on `ext_valid && ext_ready`.
- R7: Each output word equals its input word shifted left by GAIN_SH, modulo 2^DATA_W, in input order. While `out_valid` is high and `out_ready` is low, the word stays stable.
- R8: Each output handshake updates each signature independently as sig ← (sig<<1) ^ (sig[23] ? 0xC20001 : 0) ^ the zero-extended output word.
- R9: Exactly N output handshakes occur, where N is the programmed count. On the edge of the last one, `busy` falls and `done` rises, and `out_valid` is low from then on.
- R10: While `done` is high, the signatures and `done` hold and `sync` is ignored. Writing either signature register returns the unit to sleep with the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | SIG_W | Configuration write data |
| sync | input | 1 | Start event; leaves sleep |
| ext_valid | input | 1 | External vector valid |
| ext_ready | output | 1 | External vector accepted this cycle if valid |
| ext_en | input | 1 | Input-enable gating external vectors |
| ext_i | input | DATA_W | External I vector |
| ext_q | input | DATA_W | External Q vector |
| out_valid | output | 1 | Path output valid |
| out_ready | input | 1 | Path output consumer ready |
| out_i | output | DATA_W | Path output I word |
| out_q | output | DATA_W | Path output Q word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Observation count reached |
| sig_i | output | SIG_W | I signature |
| sig_q | output | SIG_W | Q signature |

## Verification
The bench builds the unit with DATA_W=16, SIG_W=24, CNT_W=20, a 16-entry sine table and a gain shift of 1. With these values a full sine period and its quarter-period cosine offset wrap several times within runs of a few dozen samples, so the table index wrap is exercised. The 24-bit signature feedback term fires often, which exposes polynomial or shift errors. Random `out_ready`, `ext_valid` and `ext_en` patterns exercise stalls, input gating and ordering. Directed runs cover:
- a count of zero;
- both mode bits set;
- writes issued mid-run;
- a nonzero signature preload;
- the freeze after `done`.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2
  } run_state_e;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_SINE = 2'd1,
    SRC_PRNG = 2'd2
  } src_sel_e;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_MODE  = 2'd1;
  localparam logic [1:0] ADDR_SIG_I = 2'd2;
  localparam logic [1:0] ADDR_SIG_Q = 2'd3;

  localparam int MODE_SINE_BIT = 6;
  localparam int MODE_PRNG_BIT = 7;

  // Pseudo-random selection wins over sine when both bits are set.
  function automatic src_sel_e decode_mode(input logic prng_bit, input logic sine_bit);
    if (prng_bit)      return SRC_PRNG;
    else if (sine_bit) return SRC_SINE;
    else               return SRC_EXT;
  endfunction

endpackage

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int SIG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [SIG_W-1:0] cfg_wdata,
  input  logic             sync,
  input  logic             obs_fire,
  output src_sel_e         src_sel,
  output logic             start,
  output logic             busy,
  output logic             done,
  output logic             sig_i_load,
  output logic             sig_q_load,
  output logic [SIG_W-1:0] sig_load_val
);

  run_state_e       state_q;
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] count_q;
  logic             wr_ok;
  logic             last_fire;

  assign busy  = (state_q == ST_RUN);
  assign done  = (state_q == ST_DONE);
  assign start = (state_q == ST_SLEEP) && sync;

  // Configuration is frozen for the length of a run.
  assign wr_ok        = cfg_we && !busy;
  assign sig_i_load   = wr_ok && (cfg_addr == ADDR_SIG_I);
  assign sig_q_load   = wr_ok && (cfg_addr == ADDR_SIG_Q);
  assign sig_load_val = cfg_wdata;

  assign last_fire = busy && obs_fire && ((count_q + 1'b1) == target_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      src_sel  <= SRC_EXT;
    end else if (wr_ok) begin
      if (cfg_addr == ADDR_COUNT) target_q <= cfg_wdata[CNT_W-1:0];
      if (cfg_addr == ADDR_MODE)
        src_sel <= decode_mode(cfg_wdata[MODE_PRNG_BIT], cfg_wdata[MODE_SINE_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      count_q <= '0;
    end else begin
      unique case (state_q)
        ST_SLEEP: begin
          if (sync) begin
            count_q <= '0;
            state_q <= (target_q == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (obs_fire) count_q <= count_q + 1'b1;
          if (last_fire) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (sig_i_load || sig_q_load) state_q <= ST_SLEEP;
        end
        default: state_q <= ST_SLEEP;
      endcase
    end
  end

endmodule

// File: rtl/sst_source.sv
module sst_source
  import sst_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          SINE_LEN  = 32,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  src_sel_e          src_sel,
  input  logic              stage_room,
  input  logic              ext_valid,
  input  logic              ext_en,
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] ext_q,
  output logic              ext_ready,
  output logic              src_valid,
  output logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] src_q
);

  localparam int PH_W  = $clog2(SINE_LEN);
  localparam int HALF  = SINE_LEN / 2;
  localparam int QTR   = SINE_LEN / 4;
  localparam int AMP   = 2 ** (DATA_W - 2);

  function automatic logic [DATA_W-1:0] sine_at(input int p);
    int r;
    int mag;
    r   = p % HALF;
    mag = (AMP * 4 * r * (HALF - r)) / (HALF * HALF);
    if (p >= HALF) mag = -mag;
    return mag[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] sine_tab [SINE_LEN];

  for (genvar g = 0; g < SINE_LEN; g++) begin : g_sine
    assign sine_tab[g] = sine_at(g);
  end

  logic [15:0]     lfsr_q;
  logic [15:0]     lfsr_next;
  logic [15:0]     lfsr_swap;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_cos;
  logic            take;

  assign lfsr_next = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  assign lfsr_swap = {lfsr_q[7:0], lfsr_q[15:8]};
  assign phase_cos = phase_q + PH_W'(QTR);

  assign src_valid = busy && ((src_sel != SRC_EXT) || (ext_valid && ext_en));
  assign ext_ready = busy && (src_sel == SRC_EXT) && ext_en && stage_room;
  assign take      = src_valid && stage_room;

  always_comb begin
    case (src_sel)
      SRC_PRNG: begin
        src_i = lfsr_q[DATA_W-1:0];
        src_q = lfsr_swap[DATA_W-1:0];
      end
      SRC_SINE: begin
        src_i = sine_tab[phase_q];
        src_q = sine_tab[phase_cos];
      end
      default: begin
        src_i = ext_i;
        src_q = ext_q;
      end
    endcase
  end

  // Internal sources restart at every run, so each run is repeatable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= LFSR_SEED;
      phase_q <= '0;
    end else if (start) begin
      lfsr_q  <= LFSR_SEED;
      phase_q <= '0;
    end else if (take) begin
      if (src_sel == SRC_PRNG) lfsr_q  <= lfsr_next;
      if (src_sel == SRC_SINE) phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/sst_gain_stage.sv
module sst_gain_stage #(
  parameter int DATA_W  = 16,
  parameter int GAIN_SH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);

  logic              vld_q;
  logic [DATA_W-1:0] dat_i_q;
  logic [DATA_W-1:0] dat_q_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q && !flush;
  assign out_i     = dat_i_q;
  assign out_q     = dat_q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_i_q <= '0;
      dat_q_q <= '0;
    end else if (!flush && in_ready && in_valid) begin
      dat_i_q <= in_i << GAIN_SH;
      dat_q_q <= in_q << GAIN_SH;
    end
  end

endmodule

// File: rtl/sst_misr.sv
module sst_misr #(
  parameter int             DATA_W = 16,
  parameter int             SIG_W  = 24,
  parameter logic [SIG_W-1:0] POLY = 24'hC20001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIG_W-1:0]  load_val,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  output logic [SIG_W-1:0]  sig
);

  logic [SIG_W-1:0] sig_next;

  assign sig_next = {sig[SIG_W-2:0], 1'b0}
                  ^ (sig[SIG_W-1] ? POLY : '0)
                  ^ SIG_W'(data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (load)  sig <= load_val;
    else if (shift) sig <= sig_next;
  end

endmodule

// File: rtl/path_sig_tester.sv
module path_sig_tester
  import sst_pkg::*;
#(
  parameter int               DATA_W   = 16,
  parameter int               SIG_W    = 24,
  parameter int               CNT_W    = 20,
  parameter int               SINE_LEN = 32,
  parameter int               GAIN_SH  = 1,
  parameter logic [15:0]      LFSR_SEED = 16'hACE1,
  parameter logic [SIG_W-1:0] SIG_POLY  = 24'hC20001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [SIG_W-1:0]  cfg_wdata,
  input  logic              sync,
  input  logic              ext_valid,
  output logic              ext_ready,
  input  logic              ext_en,
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] ext_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q,
  output logic              busy,
  output logic              done,
  output logic [SIG_W-1:0]  sig_i,
  output logic [SIG_W-1:0]  sig_q
);

  localparam int LANES = 2;

  src_sel_e          src_sel;
  logic              start;
  logic              obs_fire;
  logic              sig_i_load;
  logic              sig_q_load;
  logic [SIG_W-1:0]  sig_load_val;
  logic              src_valid;
  logic              stage_room;
  logic [DATA_W-1:0] src_i;
  logic [DATA_W-1:0] src_q;

  logic [DATA_W-1:0] lane_data [LANES];
  logic              lane_load [LANES];
  logic [SIG_W-1:0]  lane_sig  [LANES];

  assign obs_fire = out_valid && out_ready;

  sst_ctrl #(
    .CNT_W (CNT_W),
    .SIG_W (SIG_W)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .sync         (sync),
    .obs_fire     (obs_fire),
    .src_sel      (src_sel),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .sig_i_load   (sig_i_load),
    .sig_q_load   (sig_q_load),
    .sig_load_val (sig_load_val)
  );

  sst_source #(
    .DATA_W    (DATA_W),
    .SINE_LEN  (SINE_LEN),
    .LFSR_SEED (LFSR_SEED)
  ) i_source (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .src_sel    (src_sel),
    .stage_room (stage_room),
    .ext_valid  (ext_valid),
    .ext_en     (ext_en),
    .ext_i      (ext_i),
    .ext_q      (ext_q),
    .ext_ready  (ext_ready),
    .src_valid  (src_valid),
    .src_i      (src_i),
    .src_q      (src_q)
  );

  sst_gain_stage #(
    .DATA_W  (DATA_W),
    .GAIN_SH (GAIN_SH)
  ) i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!busy),
    .in_valid  (src_valid),
    .in_ready  (stage_room),
    .in_i      (src_i),
    .in_q      (src_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  assign lane_data[0] = out_i;
  assign lane_data[1] = out_q;
  assign lane_load[0] = sig_i_load;
  assign lane_load[1] = sig_q_load;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sst_misr #(
      .DATA_W (DATA_W),
      .SIG_W  (SIG_W),
      .POLY   (SIG_POLY)
    ) i_misr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (lane_load[l]),
      .load_val (sig_load_val),
      .shift    (obs_fire),
      .data     (lane_data[l]),
      .sig      (lane_sig[l])
    );
  end

  assign sig_i = lane_sig[0];
  assign sig_q = lane_sig[1];

endmodule

// File: rtl/path_sig_tester_chk.sv
module path_sig_tester_chk #(
  parameter int DATA_W = 16,
  parameter int SIG_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              sync,
  input logic              ext_ready,
  input logic              ext_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q,
  input logic              busy,
  input logic              done,
  input logic [SIG_W-1:0]  sig_i,
  input logic [SIG_W-1:0]  sig_q
);

  // R6
  ext_ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |-> (ext_en && busy));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!out_valid || ($stable(out_i) && $stable(out_q))));

  // R9
  state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));

  // R9
  no_out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  // R10
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_we) |=> ($stable(sig_i) && $stable(sig_q)));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_we) |=> done);

  // R3
  sync_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && sync) |=> (busy || done));

endmodule

bind path_sig_tester path_sig_tester_chk #(
  .DATA_W (DATA_W),
  .SIG_W  (SIG_W)
) i_chk (.*);

// File: tb/test_path_sig_tester.sv
module test_path_sig_tester;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int SW   = 24;
  localparam int SLEN = 16;
  localparam int MAXS = 1024;
  localparam logic [23:0] POLY = 24'hC20001;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [SW-1:0] cfg_wdata = '0;
  logic          sync = 1'b0;
  logic          ext_valid = 1'b0;
  logic          ext_ready;
  logic          ext_en = 1'b0;
  logic [DW-1:0] ext_i = '0;
  logic [DW-1:0] ext_q = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_i;
  logic [DW-1:0] out_q;
  logic          busy;
  logic          done;
  logic [SW-1:0] sig_i;
  logic [SW-1:0] sig_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [DW-1:0] src_i [MAXS];
  logic [DW-1:0] src_q [MAXS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  path_sig_tester #(
    .DATA_W (DW), .SIG_W (SW), .CNT_W (20), .SINE_LEN (SLEN), .GAIN_SH (1)
  ) i_path_sig_tester (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
    .cfg_wdata (cfg_wdata), .sync (sync), .ext_valid (ext_valid),
    .ext_ready (ext_ready), .ext_en (ext_en), .ext_i (ext_i), .ext_q (ext_q),
    .out_valid (out_valid), .out_ready (out_ready), .out_i (out_i),
    .out_q (out_q), .busy (busy), .done (done), .sig_i (sig_i), .sig_q (sig_q)
  );

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [DW-1:0] sine_ref(input int p);
    int h = SLEN / 2;
    int r = p % h;
    int m = ((2 ** (DW - 2)) * 4 * r * (h - r)) / (h * h);
    if (p >= h) m = -m;
    return m[DW-1:0];
  endfunction

  function automatic logic [23:0] misr_ref(input logic [23:0] s, input logic [DW-1:0] d);
    return {s[22:0], 1'b0} ^ (s[23] ? POLY : 24'h0) ^ {8'h0, d};
  endfunction

  function automatic logic [DW-1:0] gain_ref(input logic [DW-1:0] x);
    return x << 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] a, input logic [SW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input logic [23:0] mode, input int n,
                          input logic [23:0] pre_i, input logic [23:0] pre_q,
                          input bit poke);
    int sel;
    int ne;
    int no;
    int ph;
    logic [15:0] s;
    logic [23:0] ei;
    logic [23:0] eq;
    bit prev_hold;
    logic [DW-1:0] prev_i;
    logic [DW-1:0] prev_q;
    write_cfg(2'd2, pre_i);
    write_cfg(2'd3, pre_q);
    write_cfg(2'd0, 24'(n));
    write_cfg(2'd1, mode);
    sel = mode[7] ? 2 : (mode[6] ? 1 : 0);
    s = 16'hACE1; ph = 0;
    for (int k = 0; k < MAXS; k++) begin
      if (sel == 2) begin
        src_i[k] = s; src_q[k] = {s[7:0], s[15:8]}; s = lfsr_step(s);
      end else if (sel == 1) begin
        src_i[k] = sine_ref(ph); src_q[k] = sine_ref((ph + SLEN / 4) % SLEN);
        ph = (ph + 1) % SLEN;
      end
    end
    ei = pre_i; eq = pre_q; ne = 0; no = 0; prev_hold = 1'b0;
    prev_i = '0; prev_q = '0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      sync      = (cyc == 0);
      out_ready = ($urandom % 4) != 0;
      ext_valid = ($urandom % 3) != 0;
      ext_en    = ($urandom % 5) != 0;
      ext_i     = 16'($urandom);
      ext_q     = 16'($urandom);
      if (poke && cyc == 6) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 24'd2; end
      if (poke && cyc == 7) begin cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 24'h123; end
      if (poke && cyc == 8) cfg_we = 1'b0;
      #(CLK_PERIOD / 2 - 1);
      if (cyc == 1) check(busy == (n != 0), "R3", "busy after sync", busy, n != 0);
      if (prev_hold && out_valid)
        check(out_i == prev_i && out_q == prev_q, "R7", "stalled word held", out_i, prev_i);
      if (ext_ready)
        check(ext_en && sel == 0, "R6", "ext_ready gating", ext_en, 1);
      if (ext_valid && ext_ready && ne < MAXS) begin
        src_i[ne] = ext_i; src_q[ne] = ext_q; ne++;
      end
      if (out_valid && out_ready && no < MAXS) begin
        check(out_i == gain_ref(src_i[no]), "R7", "out_i word", out_i, gain_ref(src_i[no]));
        check(out_q == gain_ref(src_q[no]), "R7", "out_q word", out_q, gain_ref(src_q[no]));
        ei = misr_ref(ei, gain_ref(src_i[no]));
        eq = misr_ref(eq, gain_ref(src_q[no]));
        no++;
      end
      prev_hold = out_valid && !out_ready;
      prev_i = out_i; prev_q = out_q;
      if (cyc > 0 && done) break;
    end
    ext_valid = 1'b0;
    check(done == 1'b1, "R9", "done at end", done, 1);
    check(busy == 1'b0, "R9", "busy low at end", busy, 0);
    check(no == n, "R9", "handshake count", no, n);
    check(sig_i == ei, "R8", "sig_i", sig_i, ei);
    check(sig_q == eq, "R8", "sig_q", sig_q, eq);
  endtask

  task automatic hold_case;
    logic [23:0] si;
    logic [23:0] sq;
    si = sig_i; sq = sig_q;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      sync = (c == 2);
      out_ready = 1'b1;
      #(CLK_PERIOD / 2 - 1);
      if (c > 2) begin
        check(done && !out_valid, "R10", "done held, no output", done, 1);
        check(sig_i == si && sig_q == sq, "R10", "signatures frozen", sig_i, si);
      end
    end
    write_cfg(2'd2, 24'h0);
    #1;
    check(!done && !busy, "R10", "signature write returns to sleep", done, 0);
    check(sig_i == 24'h0, "R10", "sig_i loaded", sig_i, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] first_i;
    logic [23:0] first_q;
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    #1;
    // R1
    check(!busy && !done && !out_valid && !ext_ready, "R1", "idle flags in reset", {busy, done, out_valid, ext_ready}, 0);
    check(sig_i == 0 && sig_q == 0, "R1", "signatures in reset", sig_i, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!busy && !done && sig_i == 0 && sig_q == 0, "R1", "state after reset", {busy, done}, 0);

    // R4 pseudo-random run, then repeat it for identical signatures
    run_case(24'h80, 40, 24'h0, 24'h0, 1'b0);
    first_i = sig_i; first_q = sig_q;
    hold_case();
    run_case(24'h80, 40, 24'h0, 24'h0, 1'b0);
    check(sig_i == first_i && sig_q == first_q, "R4", "repeatable signature", sig_i, first_i);

    // R5 sine source, several period wraps
    run_case(24'h40, 37, 24'h0, 24'h0, 1'b0);
    // R6 external vectors with random input-enable
    run_case(24'h00, 30, 24'h0, 24'h0, 1'b0);
    // R2 both mode bits set selects pseudo-random
    run_case(24'hC0, 20, 24'h0, 24'h0, 1'b0);
    // R3 count of zero finishes at once with the preload intact
    run_case(24'h80, 0, 24'h111, 24'h222, 1'b0);
    // R2 writes during a run are ignored
    run_case(24'h40, 40, 24'h0, 24'h0, 1'b1);
    // R8 nonzero preload folds in
    run_case(24'h80, 25, 24'hABCDEF, 24'h5A5A5A, 1'b0);
    hold_case();

    for (int t = 0; t < 6; t++) begin
      logic [23:0] m;
      int pick;
      pick = $urandom % 4;
      m = (pick == 0) ? 24'h00 : (pick == 1) ? 24'h40 : (pick == 2) ? 24'h80 : 24'hC0;
      run_case(m, 1 + ($urandom % 200), 24'h0, 24'h0, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule